// File: doc/BRIEF.md
# Control-Opcode Screen with Exception Cause Generation

This block sits beside the main instruction decoder and examines every fetched instruction word for a small family of operand-free control instructions. Two fixed opcodes raise an exception: a 16-bit software-exception word and a 32-bit unimplemented-instruction word. Each asks the interrupt latch to set its exception line and loads a 4-bit cause code. The cause values differ between two core generations, and a build parameter selects which generation's codes are produced. Three further fixed 16-bit opcodes (barrier synchronisation, wired-AND and breakpoint) are flagged for the pipeline. Anything that matches none of the known patterns sets an illegal-opcode flag.

The block also enforces a user/supervisor rule. When the privilege enable taken from configuration bit 25 is set and status bit 2 is clear (user mode), the interrupt-enable, interrupt-disable, return-from-interrupt and system-register move instructions are refused. The block then pulses a violation output in place of the instruction's enable. Separately, a combinational helper turns a system-register byte address into its 4-bit register number.

All instruction outcomes come from a registered outcome state machine with five states. ST_IDLE means no word was accepted last cycle. ST_EXC means an exception request was issued. ST_CTRL means a control enable was issued. ST_VIOL means a privilege violation. ST_ILL means an illegal opcode. Every clock edge takes a transition chosen only by the current input. With no valid word, the machine goes to ST_IDLE. An exception opcode goes to ST_EXC. Sync, wired-AND, breakpoint, or a privileged opcode that is allowed, goes to ST_CTRL. A privileged opcode in blocked user mode goes to ST_VIOL. An unknown word goes to ST_ILL. The machine can move from any state to any state, so every outcome lasts exactly one cycle.

Top module: `ctl_op_screen`

## Requirements
- R1: A 16-bit word equal to 0x01E2 raises an exception request. The request sets `exc_latch` bit 1 only, and `exc_cause` becomes 4'b0001 with GEN=0 or 4'b1110 with GEN=1.
- R2: A 32-bit word equal to 0x000F000F raises an exception request on `exc_latch` bit 1, and `exc_cause` becomes 4'b0100 with GEN=0 or 4'b1111 with GEN=1. Exception opcodes are never subject to the privilege check.
- R3: 16-bit words 0x01F2, 0x0182 and 0x03C2 pulse `sync_en`, `wand_en` and `bkpt_en` respectively, with no exception.
- R4: For a 16-bit word (`in_is32`=0), bits 31:16 of `in_word` are ignored. A 16-bit opcode presented as a 32-bit word is illegal.
- R5: The privilege check is active only when `cfg_priv_en` (configuration bit 25) is 1. `stat_super` (status bit 2) equal to 0 means user mode.
- R6: With the check active and in user mode, words 0x0192 (interrupt enable), 0x0392 (interrupt disable), 0x01D2 (return from interrupt) and any system-register move pulse `priv_viol`, and every enable stays 0.
- R7: A 16-bit word with bits 15:14 = 0 and bits 9:0 = 0x102 is a move to a system register, and bits 9:0 = 0x112 is a move from one. `sreg_mov_en` pulses, `sreg_mov_to` is 1 for the move to, and `sreg_mov_num` carries bits 13:10.
- R8: A word matching no pattern pulses `illegal_op` and raises no exception request.
- R9: `exc_cause` is registered. It is 0 after reset and changes only in the cycle an exception request is issued.
- R10: Each outcome appears in the cycle after the clock edge that accepts the word and lasts one cycle. A cycle with `in_valid`=0 gives all-zero outcome outputs in the next cycle.
- R11: `sra_num` = (`sra_addr` − 0xF0400)/4 − 1. `sra_ok` is 1 only for word-aligned addresses 0xF0404 through 0xF0440 (numbers 0 to 15).
- R12: When allowed (check inactive or supervisor mode), words 0x0192, 0x0392 and 0x01D2 pulse `gie_en`, `gid_en` and `rti_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word; 16-bit forms use bits 15:0 |
| in_is32 | input | 1 | Word is a 32-bit instruction |
| cfg_priv_en | input | 1 | Privilege enable (configuration bit 25) |
| stat_super | input | 1 | Supervisor mode (status bit 2) |
| sra_addr | input | ADDR_W | System-register byte address to map |
| exc_latch | output | LATCH_W | Exception latch request, one-hot at LATCH_BIT |
| exc_cause | output | 4 | Registered exception cause code |
| sync_en | output | 1 | Synchronisation opcode pulse |
| wand_en | output | 1 | Wired-AND opcode pulse |
| bkpt_en | output | 1 | Breakpoint opcode pulse |
| gie_en | output | 1 | Interrupt-enable pulse |
| gid_en | output | 1 | Interrupt-disable pulse |
| rti_en | output | 1 | Return-from-interrupt pulse |
| sreg_mov_en | output | 1 | System-register move pulse |
| sreg_mov_to | output | 1 | Move direction: 1 = into the system register |
| sreg_mov_num | output | 4 | Register number of the move |
| priv_viol | output | 1 | Privilege violation pulse |
| illegal_op | output | 1 | Unrecognised opcode pulse |
| sra_num | output | SREG_NUM_W | Register number for `sra_addr` |
| sra_ok | output | 1 | `sra_addr` lies on a valid register slot |

## Verification
The bench builds two copies side by side from the same stimulus: `uut` with GEN=0 and `uut_b` with GEN=1. This puts both generations' cause tables under the same instruction stream, and a swapped or shared code shows up on one copy. The remaining parameters keep their defaults, so the latch line is bit 1 and the register window covers sixteen slots from 0xF0404. With those defaults, both edges of the address window and the misaligned cases can be reached with a handful of addresses.

// File: rtl/ctlop_pkg.sv
package ctlop_pkg;

    localparam int CAUSE_W = 4;
    localparam int MOVN_W  = 4;

    typedef enum logic [3:0] {
        K_NONE, K_SWI, K_UNIMPL, K_SYNC, K_WAND, K_BKPT,
        K_GIE, K_GID, K_RTI, K_MOVTS, K_MOVFS, K_BAD
    } op_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXC, ST_CTRL, ST_VIOL, ST_ILL
    } out_state_t;

    localparam logic [15:0] OPW_SWI  = 16'h01E2;
    localparam logic [15:0] OPW_SYNC = 16'h01F2;
    localparam logic [15:0] OPW_WAND = 16'h0182;
    localparam logic [15:0] OPW_BKPT = 16'h03C2;
    localparam logic [15:0] OPW_GIE  = 16'h0192;
    localparam logic [15:0] OPW_GID  = 16'h0392;
    localparam logic [15:0] OPW_RTI  = 16'h01D2;
    localparam logic [31:0] OPW_UNIMPL = 32'h000F000F;
    localparam logic [9:0]  OPW_MOVTS_LO = 10'h102;
    localparam logic [9:0]  OPW_MOVFS_LO = 10'h112;

    function automatic logic kind_is_priv(op_kind_t k);
        return (k == K_GIE) || (k == K_GID) || (k == K_RTI) ||
               (k == K_MOVTS) || (k == K_MOVFS);
    endfunction

endpackage

// File: rtl/ctlop_classify.sv
module ctlop_classify
    import ctlop_pkg::*;
(
    input  logic [31:0]       word,
    input  logic              is32,
    output op_kind_t          kind,
    output logic [MOVN_W-1:0] mov_num
);

    logic [15:0] lo;
    logic        mov_frame;

    assign lo        = word[15:0];
    assign mov_frame = (lo[15:14] == 2'b00);
    assign mov_num   = lo[13:10];

    always_comb begin
        kind = K_BAD;
        if (is32) begin
            if (word == OPW_UNIMPL) kind = K_UNIMPL;
        end else begin
            if      (lo == OPW_SWI)  kind = K_SWI;
            else if (lo == OPW_SYNC) kind = K_SYNC;
            else if (lo == OPW_WAND) kind = K_WAND;
            else if (lo == OPW_BKPT) kind = K_BKPT;
            else if (lo == OPW_GIE)  kind = K_GIE;
            else if (lo == OPW_GID)  kind = K_GID;
            else if (lo == OPW_RTI)  kind = K_RTI;
            else if (mov_frame && lo[9:0] == OPW_MOVTS_LO) kind = K_MOVTS;
            else if (mov_frame && lo[9:0] == OPW_MOVFS_LO) kind = K_MOVFS;
        end
    end

    // R4: a 32-bit word only ever classifies as the unimplemented exception or illegal
    always_comb begin
        if (is32) a_r4_wide_class: assert (kind == K_UNIMPL || kind == K_BAD);
    end

endmodule

// File: rtl/ctlop_sreg_map.sv
module ctlop_sreg_map #(
    parameter int          ADDR_W = 20,
    parameter int          NUM_W  = 4,
    parameter logic [31:0] BASE   = 32'h000F_0400
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_W-1:0]  num,
    output logic              ok
);

    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LO_V   = ADDR_W'(BASE + 32'd4);
    localparam logic [ADDR_W-1:0] HI_V   = ADDR_W'(BASE + 32'd4 * (32'd1 << NUM_W));

    logic [ADDR_W-1:0] slot;

    assign slot = (addr - BASE_V) >> 2;
    assign num  = NUM_W'(slot - ADDR_W'(1));
    assign ok   = (addr[1:0] == 2'b00) && (addr >= LO_V) && (addr <= HI_V);

    // R11: a valid slot is always word aligned and inside the window
    always_comb begin
        if (ok) a_r11_slot_in_window: assert (addr[1:0] == 2'b00 && addr > BASE_V);
    end

endmodule

// File: rtl/ctlop_fsm.sv
module ctlop_fsm
    import ctlop_pkg::*;
#(
    parameter int GEN       = 0,
    parameter int LATCH_W   = 10,
    parameter int LATCH_BIT = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  op_kind_t           kind,
    input  logic [MOVN_W-1:0]  mov_num_in,
    input  logic               priv_on,
    input  logic               super_mode,
    output logic [LATCH_W-1:0] exc_latch,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic               sync_en,
    output logic               wand_en,
    output logic               bkpt_en,
    output logic               gie_en,
    output logic               gid_en,
    output logic               rti_en,
    output logic               sreg_mov_en,
    output logic               sreg_mov_to,
    output logic [MOVN_W-1:0]  sreg_mov_num,
    output logic               priv_viol,
    output logic               illegal_op
);

    logic [CAUSE_W-1:0] code_swi;
    logic [CAUSE_W-1:0] code_uni;

    generate
        if (GEN == 0) begin : g_gen_a
            assign code_swi = 4'b0001;
            assign code_uni = 4'b0100;
        end else begin : g_gen_b
            assign code_swi = 4'b1110;
            assign code_uni = 4'b1111;
        end
    endgenerate

    out_state_t         state, nxt;
    op_kind_t           kind_q;
    logic [MOVN_W-1:0]  num_q;
    logic [CAUSE_W-1:0] cause_q;
    logic               blocked;

    assign blocked = priv_on && !super_mode;

    always_comb begin
        nxt = ST_IDLE;
        if (in_valid) begin
            unique case (kind)
                K_SWI, K_UNIMPL:                      nxt = ST_EXC;
                K_SYNC, K_WAND, K_BKPT:               nxt = ST_CTRL;
                K_GIE, K_GID, K_RTI, K_MOVTS, K_MOVFS: nxt = blocked ? ST_VIOL : ST_CTRL;
                K_BAD:                                nxt = ST_ILL;
                default:                              nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= K_NONE;
            num_q   <= '0;
            cause_q <= '0;
        end else begin
            kind_q <= in_valid ? kind : K_NONE;
            num_q  <= mov_num_in;
            if (nxt == ST_EXC) cause_q <= (kind == K_UNIMPL) ? code_uni : code_swi;
        end
    end

    assign exc_cause = cause_q;

    always_comb begin
        exc_latch    = '0;
        sync_en      = 1'b0;
        wand_en      = 1'b0;
        bkpt_en      = 1'b0;
        gie_en       = 1'b0;
        gid_en       = 1'b0;
        rti_en       = 1'b0;
        sreg_mov_en  = 1'b0;
        sreg_mov_to  = 1'b0;
        sreg_mov_num = num_q;
        priv_viol    = 1'b0;
        illegal_op   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_EXC:  exc_latch[LATCH_BIT] = 1'b1;
            ST_CTRL: begin
                sync_en     = (kind_q == K_SYNC);
                wand_en     = (kind_q == K_WAND);
                bkpt_en     = (kind_q == K_BKPT);
                gie_en      = (kind_q == K_GIE);
                gid_en      = (kind_q == K_GID);
                rti_en      = (kind_q == K_RTI);
                sreg_mov_en = (kind_q == K_MOVTS) || (kind_q == K_MOVFS);
                sreg_mov_to = (kind_q == K_MOVTS);
            end
            ST_VIOL: priv_viol  = 1'b1;
            ST_ILL:  illegal_op = 1'b1;
            default: ;
        endcase
    end

    logic any_en;
    assign any_en = sync_en | wand_en | bkpt_en | gie_en | gid_en | rti_en | sreg_mov_en;

    // R10: an idle input cycle leaves every outcome output low next cycle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (exc_latch == '0 && !any_en && !priv_viol && !illegal_op));

    // R9: the cause register moves only together with an exception request
    a_r9_cause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_latch == '0) |-> $stable(exc_cause));

    // R6: a blocked privileged opcode yields a violation and no enable
    a_r6_viol_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && blocked && kind_is_priv(kind)) |=> (priv_viol && !any_en));

    // R2: the unimplemented opcode loads its generation's code
    a_r2_unimpl_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_UNIMPL) |=> (exc_cause == code_uni && exc_latch[LATCH_BIT]));

    // R8: an unknown word flags illegal and raises nothing
    a_r8_ill_no_exc: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_BAD) |=> (illegal_op && exc_latch == '0));

endmodule

// File: rtl/ctl_op_screen.sv
module ctl_op_screen
    import ctlop_pkg::*;
#(
    parameter int          GEN        = 0,
    parameter int          LATCH_W    = 10,
    parameter int          LATCH_BIT  = 1,
    parameter int          ADDR_W     = 20,
    parameter int          SREG_NUM_W = 4,
    parameter logic [31:0] SREG_BASE  = 32'h000F_0400
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [31:0]           in_word,
    input  logic                  in_is32,
    input  logic                  cfg_priv_en,
    input  logic                  stat_super,
    input  logic [ADDR_W-1:0]     sra_addr,
    output logic [LATCH_W-1:0]    exc_latch,
    output logic [3:0]            exc_cause,
    output logic                  sync_en,
    output logic                  wand_en,
    output logic                  bkpt_en,
    output logic                  gie_en,
    output logic                  gid_en,
    output logic                  rti_en,
    output logic                  sreg_mov_en,
    output logic                  sreg_mov_to,
    output logic [3:0]            sreg_mov_num,
    output logic                  priv_viol,
    output logic                  illegal_op,
    output logic [SREG_NUM_W-1:0] sra_num,
    output logic                  sra_ok
);

    op_kind_t          kind;
    logic [MOVN_W-1:0] mov_num;

    ctlop_classify u_cls (
        .word    (in_word),
        .is32    (in_is32),
        .kind    (kind),
        .mov_num (mov_num)
    );

    ctlop_fsm #(
        .GEN       (GEN),
        .LATCH_W   (LATCH_W),
        .LATCH_BIT (LATCH_BIT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .kind         (kind),
        .mov_num_in   (mov_num),
        .priv_on      (cfg_priv_en),
        .super_mode   (stat_super),
        .exc_latch    (exc_latch),
        .exc_cause    (exc_cause),
        .sync_en      (sync_en),
        .wand_en      (wand_en),
        .bkpt_en      (bkpt_en),
        .gie_en       (gie_en),
        .gid_en       (gid_en),
        .rti_en       (rti_en),
        .sreg_mov_en  (sreg_mov_en),
        .sreg_mov_to  (sreg_mov_to),
        .sreg_mov_num (sreg_mov_num),
        .priv_viol    (priv_viol),
        .illegal_op   (illegal_op)
    );

    ctlop_sreg_map #(
        .ADDR_W (ADDR_W),
        .NUM_W  (SREG_NUM_W),
        .BASE   (SREG_BASE)
    ) u_map (
        .addr (sra_addr),
        .num  (sra_num),
        .ok   (sra_ok)
    );

endmodule

// File: tb/ctl_op_screen_test.sv
module ctl_op_screen_test;

    localparam int NV = 18;
    localparam int VW = 58;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_is32 = 1'b0;
    logic        cfg_priv_en = 1'b0;
    logic        stat_super = 1'b0;
    logic [19:0] sra_addr = '0;

    logic [9:0] exc_latch, exc_latch_b;
    logic [3:0] exc_cause, exc_cause_b, sreg_mov_num, sreg_mov_num_b, sra_num, sra_num_b;
    logic sync_en, wand_en, bkpt_en, gie_en, gid_en, rti_en, sreg_mov_en, sreg_mov_to;
    logic priv_viol, illegal_op, sra_ok;
    logic sync_b, wand_b, bkpt_b, gie_b, gid_b, rti_b, mov_b, movto_b, viol_b, ill_b, ok_b;

    always #4 clk = ~clk;

    ctl_op_screen #(.GEN(0)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_is32(in_is32),
        .cfg_priv_en(cfg_priv_en), .stat_super(stat_super), .sra_addr(sra_addr),
        .exc_latch(exc_latch), .exc_cause(exc_cause), .sync_en(sync_en), .wand_en(wand_en),
        .bkpt_en(bkpt_en), .gie_en(gie_en), .gid_en(gid_en), .rti_en(rti_en),
        .sreg_mov_en(sreg_mov_en), .sreg_mov_to(sreg_mov_to), .sreg_mov_num(sreg_mov_num),
        .priv_viol(priv_viol), .illegal_op(illegal_op), .sra_num(sra_num), .sra_ok(sra_ok));

    ctl_op_screen #(.GEN(1)) uut_b (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_is32(in_is32),
        .cfg_priv_en(cfg_priv_en), .stat_super(stat_super), .sra_addr(sra_addr),
        .exc_latch(exc_latch_b), .exc_cause(exc_cause_b), .sync_en(sync_b), .wand_en(wand_b),
        .bkpt_en(bkpt_b), .gie_en(gie_b), .gid_en(gid_b), .rti_en(rti_b),
        .sreg_mov_en(mov_b), .sreg_mov_to(movto_b), .sreg_mov_num(sreg_mov_num_b),
        .priv_viol(viol_b), .illegal_op(ill_b), .sra_num(sra_num_b), .sra_ok(ok_b));

    // fields: is32, word, priv enable, supervisor, flags{exc,sync,wand,bkpt,gie,gid,rti,mov,viol,ill},
    //         cause GEN0, cause GEN1, move number, move direction
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 32'h000001E2, 1'b0, 1'b0, 10'b1000000000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h000001F2, 1'b0, 1'b0, 10'b0100000000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h00000182, 1'b0, 1'b0, 10'b0010000000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h000003C2, 1'b0, 1'b0, 10'b0001000000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b1, 32'h000F000F, 1'b0, 1'b0, 10'b1000000000, 4'h4, 4'hF, 4'h0, 1'b0},
        {1'b0, 32'hABCD01E2, 1'b0, 1'b0, 10'b1000000000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b1, 32'h000001E2, 1'b0, 1'b0, 10'b0000000001, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h00000192, 1'b1, 1'b0, 10'b0000000010, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h00000192, 1'b1, 1'b1, 10'b0000100000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h00000392, 1'b0, 1'b0, 10'b0000010000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h000001D2, 1'b1, 1'b0, 10'b0000000010, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h000001D2, 1'b1, 1'b1, 10'b0000001000, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h00000502, 1'b1, 1'b0, 10'b0000000010, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b0, 32'h00000912, 1'b1, 1'b1, 10'b0000000100, 4'h1, 4'hE, 4'h2, 1'b0},
        {1'b0, 32'h00000502, 1'b0, 1'b0, 10'b0000000100, 4'h1, 4'hE, 4'h1, 1'b1},
        {1'b0, 32'h00001234, 1'b0, 1'b0, 10'b0000000001, 4'h1, 4'hE, 4'h0, 1'b0},
        {1'b1, 32'h000F000F, 1'b1, 1'b0, 10'b1000000000, 4'h4, 4'hF, 4'h0, 1'b0},
        {1'b0, 32'h000F000F, 1'b0, 1'b0, 10'b0000000001, 4'h4, 4'hF, 4'h0, 1'b0}
    };

    string vtag [NV] = '{"R1", "R3", "R3", "R3", "R2", "R4", "R4", "R6", "R12",
                         "R5", "R6", "R12", "R6", "R7", "R7", "R8", "R2", "R8"};

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!good) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] flags_a();
        return {|exc_latch, sync_en, wand_en, bkpt_en, gie_en, gid_en, rti_en, sreg_mov_en, priv_viol, illegal_op};
    endfunction

    function automatic logic [9:0] flags_b();
        return {|exc_latch_b, sync_b, wand_b, bkpt_b, gie_b, gid_b, rti_b, mov_b, viol_b, ill_b};
    endfunction

    task automatic map_chk(input logic [19:0] a, input logic ok_e, input logic [3:0] num_e);
        sra_addr = a;
        #1;
        chk(sra_ok == ok_e, "R11 ok", 64'(sra_ok), 64'(ok_e));
        if (ok_e) chk(sra_num == num_e, "R11 num", 64'(sra_num), 64'(num_e));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(flags_a() == 10'b0, "R10 reset outputs", 64'(flags_a()), 64'h0);
        chk(exc_cause == 4'h0 && exc_cause_b == 4'h0, "R9 reset cause",
            64'({exc_cause, exc_cause_b}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flags_a() == 10'b0, "R10 idle after reset", 64'(flags_a()), 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            in_valid    = 1'b1;
            in_is32     = v[57];
            in_word     = v[56:25];
            cfg_priv_en = v[24];
            stat_super  = v[23];
            @(negedge clk);
            chk(flags_a() == v[22:13], vtag[i], 64'(flags_a()), 64'(v[22:13]));
            chk(flags_b() == v[22:13], vtag[i], 64'(flags_b()), 64'(v[22:13]));
            chk(exc_cause == v[12:9], {vtag[i], " R9 cause GEN0"}, 64'(exc_cause), 64'(v[12:9]));
            chk(exc_cause_b == v[8:5], {vtag[i], " R9 cause GEN1"}, 64'(exc_cause_b), 64'(v[8:5]));
            if (v[22]) chk(exc_latch == 10'b10, "R1 latch bit", 64'(exc_latch), 64'h2);
            if (v[15]) begin
                chk(sreg_mov_num == v[4:1], "R7 move num", 64'(sreg_mov_num), 64'(v[4:1]));
                chk(sreg_mov_to == v[0], "R7 move dir", 64'(sreg_mov_to), 64'(v[0]));
            end
        end

        in_valid = 1'b0;
        in_word  = 32'h000001E2;
        @(negedge clk);
        chk(flags_a() == 10'b0, "R10 idle quiet", 64'(flags_a()), 64'h0);
        chk(exc_cause == 4'h4 && exc_cause_b == 4'hF, "R9 cause held",
            64'({exc_cause, exc_cause_b}), 64'h4F);

        in_valid = 1'b1;
        in_is32  = 1'b0;
        in_word  = 32'h000001F2;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(sync_en == 1'b0, "R10 single-cycle pulse", 64'(sync_en), 64'h0);

        map_chk(20'hF0404, 1'b1, 4'd0);
        map_chk(20'hF0408, 1'b1, 4'd1);
        map_chk(20'hF040C, 1'b1, 4'd2);
        map_chk(20'hF0440, 1'b1, 4'd15);
        map_chk(20'hF0444, 1'b0, 4'd0);
        map_chk(20'hF0400, 1'b0, 4'd0);
        map_chk(20'hF040A, 1'b0, 4'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule